// File: doc/BRIEF.md
# STN Panel Timing Generator

This block drives a passive-matrix STN panel from the chip's main clock. It produces the pixel shift clock (`cp`), the row latch pulse (`lp`), the frame-start marker (`flm`), the AC drive polarity signal (`m`) and an 8-bit pixel bus (`vd`). Pixel bytes come from an external fetch unit through a show-ahead interface. In the cycle where `px_req` is high, the fetch unit must present on `px_byte` the byte addressed by `pos_line` and `pos_col`.

The configuration is static while the block runs and may change only under reset. It gives the line width in pixels (a multiple of 8), the panel height in rows (even in dual scan), and the bus arrangement: single scan on four data lines, single scan on eight, or dual scan with two half-panels. It also gives the latch pulse width in main-clock cycles (at least 1), the number of rows between polarity flips (at least 1), and a panel power enable bit. Each shift-clock period takes two main-clock cycles: high for one, low for one.

Top module: `stn_panel_timing`

## Requirements
- R1: While `rst` is high, and in the cycle after the first clock edge under reset, `cp`, `lp`, `flm`, `m`, `lcd_en` and `vd` are all 0.
- R2: Each row carries C shift-clock pulses. C is width/4 for single scan on four lines and for dual scan, and width/8 for single scan on eight lines. Each pulse is high for exactly one cycle and low for exactly one cycle. The first pulse rises on the first edge after reset.
- R3: `vd` changes only on the edge where `cp` rises, so it is stable across the falling edge of `cp`.
- R4: `lp` rises on the edge where the last `cp` of a row falls and stays high for exactly `cfg_lpw` cycles, with `cp` held low. A row therefore lasts 2*C+`cfg_lpw` cycles.
- R5: `flm` rises on the first `cp` rising edge of row 0 and falls on the first `cp` rising edge of row 1, so it is high across the falling edge of row 0's `lp`.
- R6: `m` starts at 0 and inverts on the `lp` falling edge of every `cfg_mper`-th row, counting rows continuously across frames.
- R7: `pos_line` counts rows from 0, advances on each `lp` falling edge, and wraps to 0 after `cfg_height`-1 (single scan) or `cfg_height`/2-1 (dual scan). `flm` is raised again at every wrap.
- R8: Single scan on four lines (`cfg_dual`=0, `cfg_bus8`=0): each byte feeds two `cp` pulses, bits [7:4] first and then bits [3:0], always on `vd[7:4]`, with `vd[3:0]`=0.
- R9: Single scan on eight lines (`cfg_dual`=0, `cfg_bus8`=1) and dual scan (`cfg_dual`=1, `cfg_bus8` ignored): each byte feeds one `cp` pulse and appears unchanged on `vd`. In dual scan, bits [7:4] belong to the upper half-panel and bits [3:0] to the lower.
- R10: `pos_col` is the index of the next byte of the current row, starting at 0 on each row. `px_req` is high, with `cp` low, in the cycle where `px_byte` is taken.
- R11: `lcd_en` equals `cfg_lcd_en` delayed by one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_width | input | W_BITS | Row width in pixels, multiple of 8 |
| cfg_height | input | H_BITS | Panel height in rows |
| cfg_dual | input | 1 | 1 = dual scan |
| cfg_bus8 | input | 1 | 1 = eight data lines (single scan only) |
| cfg_lpw | input | LPW_BITS | Latch pulse width in cycles, at least 1 |
| cfg_mper | input | MPER_BITS | Rows between `m` flips, at least 1 |
| cfg_lcd_en | input | 1 | Panel power enable request |
| px_byte | input | 8 | Pixel byte from fetch unit |
| px_req | output | 1 | Byte taken this cycle |
| pos_col | output | W_BITS | Byte index within the row |
| pos_line | output | H_BITS | Row index within the frame (half-frame in dual scan) |
| cp | output | 1 | Pixel shift clock |
| lp | output | 1 | Row latch pulse |
| flm | output | 1 | Frame-start marker |
| m | output | 1 | AC drive polarity |
| vd | output | 8 | Pixel data bus |
| lcd_en | output | 1 | Panel power enable, low after reset |

## Verification
Every output is registered, so a result caused by edge e is sampled on the falling edge right after edge e. The bench counts edges from the first edge after reset. Within a row of period P=2*C+`cfg_lpw`, `cp` is high on even offsets below 2*C. `lp` is high on offsets 2*C-1 through P-2. `pos_line` and `m` move on offset P-1, and `flm` and the row's first byte move on offset 0 of the following row. The bench derives each expected value from the edge number and checks it against the outputs on every cycle.

// File: rtl/stn_pkg.sv
package stn_pkg;
  typedef enum logic [1:0] {
    BM_S4   = 2'd0,
    BM_S8   = 2'd1,
    BM_DUAL = 2'd2
  } bus_mode_e;

  typedef enum logic {
    SQ_DATA  = 1'b0,
    SQ_LATCH = 1'b1
  } seq_state_e;

  function automatic bus_mode_e decode_mode(input logic dual, input logic bus8);
    if (dual) return BM_DUAL;
    else if (bus8) return BM_S8;
    else return BM_S4;
  endfunction
endpackage

// File: rtl/stn_shift_seq.sv
module stn_shift_seq
  import stn_pkg::*;
#(
  parameter int W_BITS   = 11,
  parameter int LPW_BITS = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  bus_mode_e           mode,
  input  logic [W_BITS-1:0]   cfg_width,
  input  logic [LPW_BITS-1:0] cfg_lpw,
  output logic                cp,
  output logic                lp,
  output logic                shift_en,
  output logic                line_start,
  output logic                line_adv
);
  localparam logic [W_BITS-1:0]   W_ONE = W_BITS'(1);
  localparam logic [LPW_BITS-1:0] L_ONE = LPW_BITS'(1);

  seq_state_e          st_q;
  logic                ph_q;
  logic [W_BITS-1:0]   cp_idx_q;
  logic [LPW_BITS-1:0] lp_cnt_q;
  logic                cp_q, lp_q;
  logic [W_BITS-1:0]   cpl;

  always_comb begin
    if (mode == BM_S8) cpl = cfg_width >> 3;
    else               cpl = cfg_width >> 2;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= SQ_DATA;
      ph_q     <= 1'b0;
      cp_idx_q <= '0;
      lp_cnt_q <= '0;
      cp_q     <= 1'b0;
      lp_q     <= 1'b0;
    end else begin
      case (st_q)
        SQ_DATA: begin
          if (!ph_q) begin
            cp_q <= 1'b1;
            ph_q <= 1'b1;
          end else begin
            cp_q <= 1'b0;
            ph_q <= 1'b0;
            if (cp_idx_q == cpl - W_ONE) begin
              cp_idx_q <= '0;
              st_q     <= SQ_LATCH;
              lp_q     <= 1'b1;
              lp_cnt_q <= '0;
            end else begin
              cp_idx_q <= cp_idx_q + W_ONE;
            end
          end
        end
        default: begin
          if (lp_cnt_q == cfg_lpw - L_ONE) begin
            lp_q <= 1'b0;
            st_q <= SQ_DATA;
          end else begin
            lp_cnt_q <= lp_cnt_q + L_ONE;
          end
        end
      endcase
    end
  end

  assign shift_en   = (st_q == SQ_DATA) && !ph_q;
  assign line_start = shift_en && (cp_idx_q == '0);
  assign line_adv   = (st_q == SQ_LATCH) && (lp_cnt_q == cfg_lpw - L_ONE);
  assign cp         = cp_q;
  assign lp         = lp_q;

  // R4
  lp_cp_excl_chk: assert property (@(posedge clk) disable iff (rst) lp_q |-> !cp_q);
  // R2
  cp_pulse_chk: assert property (@(posedge clk) disable iff (rst) $rose(cp_q) |=> $fell(cp_q));
  // R4
  lp_start_chk: assert property (@(posedge clk) disable iff (rst) $rose(lp_q) |-> $fell(cp_q));
endmodule

// File: rtl/stn_line_ctr.sv
module stn_line_ctr
  import stn_pkg::*;
#(
  parameter int H_BITS    = 10,
  parameter int MPER_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  bus_mode_e            mode,
  input  logic [H_BITS-1:0]    cfg_height,
  input  logic [MPER_BITS-1:0] cfg_mper,
  input  logic                 line_start,
  input  logic                 line_adv,
  output logic [H_BITS-1:0]    line,
  output logic                 flm,
  output logic                 m
);
  localparam logic [H_BITS-1:0]    H_ONE = H_BITS'(1);
  localparam logic [MPER_BITS-1:0] M_ONE = MPER_BITS'(1);

  logic [H_BITS-1:0]    line_q;
  logic [MPER_BITS-1:0] mcnt_q;
  logic                 flm_q, m_q;
  logic [H_BITS-1:0]    lim;

  always_comb begin
    if (mode == BM_DUAL) lim = cfg_height >> 1;
    else                 lim = cfg_height;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      line_q <= '0;
      mcnt_q <= '0;
      flm_q  <= 1'b0;
      m_q    <= 1'b0;
    end else begin
      if (line_adv) begin
        if (line_q == lim - H_ONE) line_q <= '0;
        else                       line_q <= line_q + H_ONE;
        if (mcnt_q == cfg_mper - M_ONE) begin
          mcnt_q <= '0;
          m_q    <= ~m_q;
        end else begin
          mcnt_q <= mcnt_q + M_ONE;
        end
      end
      if (line_start) flm_q <= (line_q == '0);
    end
  end

  assign line = line_q;
  assign flm  = flm_q;
  assign m    = m_q;

  // R7
  line_range_chk: assert property (@(posedge clk) disable iff (rst) line_q < lim);
  // R5
  flm_first_chk: assert property (@(posedge clk) disable iff (rst) $rose(flm_q) |-> (line_q == '0));
  // R6
  m_step_chk: assert property (@(posedge clk) disable iff (rst) !$stable(m_q) |-> $past(line_adv));
endmodule

// File: rtl/stn_data_fmt.sv
module stn_data_fmt
  import stn_pkg::*;
#(
  parameter int W_BITS = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  bus_mode_e         mode,
  input  logic              shift_en,
  input  logic              line_adv,
  input  logic [7:0]        px_byte,
  output logic              px_req,
  output logic [7:0]        vd,
  output logic [W_BITS-1:0] byte_idx
);
  logic [7:0]        vd_q;
  logic [3:0]        hold_q;
  logic              nib_q;
  logic [W_BITS-1:0] idx_q;

  assign px_req = shift_en && ((mode != BM_S4) || !nib_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      vd_q   <= '0;
      hold_q <= '0;
      nib_q  <= 1'b0;
      idx_q  <= '0;
    end else begin
      if (shift_en) begin
        if (mode == BM_S4) begin
          if (!nib_q) begin
            vd_q   <= {px_byte[7:4], 4'h0};
            hold_q <= px_byte[3:0];
            nib_q  <= 1'b1;
          end else begin
            vd_q  <= {hold_q, 4'h0};
            nib_q <= 1'b0;
          end
        end else begin
          vd_q <= px_byte;
        end
      end
      if (line_adv) begin
        idx_q <= '0;
        nib_q <= 1'b0;
      end else if (px_req) begin
        idx_q <= idx_q + W_BITS'(1);
      end
    end
  end

  assign vd       = vd_q;
  assign byte_idx = idx_q;

  // R3
  vd_hold_chk: assert property (@(posedge clk) disable iff (rst) !$past(shift_en) |-> $stable(vd_q));
  // R8
  s4_low_zero_chk: assert property (@(posedge clk) disable iff (rst) (mode == BM_S4) |-> (vd_q[3:0] == 4'h0));
endmodule

// File: rtl/stn_panel_timing.sv
module stn_panel_timing
  import stn_pkg::*;
#(
  parameter int W_BITS    = 11,
  parameter int H_BITS    = 10,
  parameter int LPW_BITS  = 8,
  parameter int MPER_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [W_BITS-1:0]    cfg_width,
  input  logic [H_BITS-1:0]    cfg_height,
  input  logic                 cfg_dual,
  input  logic                 cfg_bus8,
  input  logic [LPW_BITS-1:0]  cfg_lpw,
  input  logic [MPER_BITS-1:0] cfg_mper,
  input  logic                 cfg_lcd_en,
  input  logic [7:0]           px_byte,
  output logic                 px_req,
  output logic [W_BITS-1:0]    pos_col,
  output logic [H_BITS-1:0]    pos_line,
  output logic                 cp,
  output logic                 lp,
  output logic                 flm,
  output logic                 m,
  output logic [7:0]           vd,
  output logic                 lcd_en
);
  bus_mode_e mode;
  logic shift_en, line_start, line_adv;
  logic lcd_en_q;

  assign mode = decode_mode(cfg_dual, cfg_bus8);

  stn_shift_seq #(.W_BITS(W_BITS), .LPW_BITS(LPW_BITS)) seq_i (
    .clk(clk), .rst(rst), .mode(mode), .cfg_width(cfg_width), .cfg_lpw(cfg_lpw),
    .cp(cp), .lp(lp), .shift_en(shift_en), .line_start(line_start), .line_adv(line_adv)
  );

  stn_line_ctr #(.H_BITS(H_BITS), .MPER_BITS(MPER_BITS)) line_i (
    .clk(clk), .rst(rst), .mode(mode), .cfg_height(cfg_height), .cfg_mper(cfg_mper),
    .line_start(line_start), .line_adv(line_adv), .line(pos_line), .flm(flm), .m(m)
  );

  stn_data_fmt #(.W_BITS(W_BITS)) fmt_i (
    .clk(clk), .rst(rst), .mode(mode), .shift_en(shift_en), .line_adv(line_adv),
    .px_byte(px_byte), .px_req(px_req), .vd(vd), .byte_idx(pos_col)
  );

  always_ff @(posedge clk) begin
    if (rst) lcd_en_q <= 1'b0;
    else     lcd_en_q <= cfg_lcd_en;
  end
  assign lcd_en = lcd_en_q;

  // R10
  req_cp_low_chk: assert property (@(posedge clk) disable iff (rst) px_req |-> (!cp && !lp));
  // R11
  en_follow_chk: assert property (@(posedge clk) disable iff (rst) !$past(rst) |-> (lcd_en_q == $past(cfg_lcd_en)));
  // R5
  flm_lp_chk: assert property (@(posedge clk) disable iff (rst) $fell(lp) |-> $stable(flm));
endmodule

// File: tb/stn_panel_timing_tb_top.sv
module stn_panel_timing_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [10:0] cfg_width = 11'd16;
  logic [9:0]  cfg_height = 10'd4;
  logic        cfg_dual = 1'b0, cfg_bus8 = 1'b0, cfg_lcd_en = 1'b0;
  logic [7:0]  cfg_lpw = 8'd1, cfg_mper = 8'd1;
  logic [7:0]  px_byte;
  logic        px_req, cp, lp, flm, m, lcd_en;
  logic [10:0] pos_col;
  logic [9:0]  pos_line;
  logic [7:0]  vd;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  function automatic logic [7:0] fb(input int l, input int c);
    return 8'((l * 37 + c * 11 + 5) & 255);
  endfunction

  assign px_byte = fb(int'(pos_line), int'(pos_col));

  stn_panel_timing dut_i (
    .clk(clk), .rst(rst), .cfg_width(cfg_width), .cfg_height(cfg_height),
    .cfg_dual(cfg_dual), .cfg_bus8(cfg_bus8), .cfg_lpw(cfg_lpw), .cfg_mper(cfg_mper),
    .cfg_lcd_en(cfg_lcd_en), .px_byte(px_byte), .px_req(px_req), .pos_col(pos_col),
    .pos_line(pos_line), .cp(cp), .lp(lp), .flm(flm), .m(m), .vd(vd), .lcd_en(lcd_en)
  );

  task automatic chk(input string req, input string what, input int got, input int exp, input int e);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s %s edge %0d: got %0d expected %0d", req, what, e, got, exp);
    end
  endtask

  task automatic run_cfg(input int w, input int h, input bit dual, input bit b8,
                         input int lpw, input int mper, input bit en);
    int cpl, per, lines, span;
    @(negedge clk);
    rst = 1'b1;
    cfg_width = 11'(w); cfg_height = 10'(h); cfg_dual = dual; cfg_bus8 = b8;
    cfg_lpw = 8'(lpw); cfg_mper = 8'(mper); cfg_lcd_en = en;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "cp", int'(cp), 0, -1);
    chk("R1", "lp", int'(lp), 0, -1);
    chk("R1", "flm", int'(flm), 0, -1);
    chk("R1", "m", int'(m), 0, -1);
    chk("R1", "lcd_en", int'(lcd_en), 0, -1);
    chk("R1", "vd", int'(vd), 0, -1);
    cpl   = (b8 && !dual) ? w / 8 : w / 4;
    per   = 2 * cpl + lpw;
    lines = dual ? h / 2 : h;
    span  = 2 * lines * per + 4;
    rst = 1'b0;
    for (int e = 0; e < span; e++) begin
      int r, lk, j, bv, exp_vd;
      @(negedge clk);
      r  = e % per;
      lk = (e / per) % lines;
      // R2 shift clock pattern
      chk("R2", "cp", int'(cp), (r < 2 * cpl && (r % 2) == 0) ? 1 : 0, e);
      // R4 latch pulse window
      chk("R4", "lp", int'(lp), (r >= 2 * cpl - 1 && r <= per - 2) ? 1 : 0, e);
      // R5 / R7 frame marker regenerated on wrap
      chk("R5", "flm", int'(flm), (lk == 0) ? 1 : 0, e);
      // R6 polarity
      chk("R6", "m", int'(m), (((e + 1) / per) / mper) % 2, e);
      // R7 row counter
      chk("R7", "pos_line", int'(pos_line), ((e + 1) / per) % lines, e);
      // R11 enable follow
      chk("R11", "lcd_en", int'(lcd_en), int'(en), e);
      // R3 R8 R9 R10 data bus
      j = (r < 2 * cpl) ? r / 2 : cpl - 1;
      if (!dual && !b8) begin
        bv = int'(fb(lk, j / 2));
        exp_vd = ((j % 2) == 1) ? ((bv & 15) << 4) : (bv & 240);
        chk("R8", "vd", int'(vd), exp_vd, e);
      end else begin
        exp_vd = int'(fb(lk, j));
        chk("R9", "vd", int'(vd), exp_vd, e);
      end
    end
  endtask

  initial begin
    run_cfg(16, 6, 1'b0, 1'b0, 3, 4, 1'b1);
    run_cfg(16, 6, 1'b0, 1'b1, 1, 1, 1'b0);
    run_cfg(24, 8, 1'b1, 1'b0, 2, 3, 1'b1);
    run_cfg(24, 8, 1'b1, 1'b1, 4, 2, 1'b0);
    run_cfg(8, 3, 1'b0, 1'b0, 5, 2, 1'b1);
    run_cfg(32, 2, 1'b0, 1'b1, 2, 5, 1'b1);
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule